// File: doc/BRIEF.md
# Segment Code Receiver and Gate Enabler

This block sits beside the switching stage of a digitally controlled buck converter whose high-side and low-side switches are each split into seven equal cells. The cells form binary-weighted groups of one, two and four, so a 3-bit code per side selects the effective switch width. A slow control domain picks these codes and sends them over an asynchronous bus. The bus has a toggle-style valid line. This block brings each new code pair into the converter clock domain and normalises it. It holds the pair pending, and then makes it the live enable set only at a high-to-low transition of the high-side PWM drive. Changing width at that point never shortens or splits a switching pulse.

Each segment gate output is the matching PWM drive gated by its enable bit. An all-zero code word selects pulse-frequency mode. In that mode every low-side (synchronous rectifier) gate is held off and the high side runs on a fixed small enable set. A nonzero word with one zero field is repaired, so that in PWM mode each side always has at least one group enabled. The producer may send a new word before the previous one has been applied, and the latest word wins. A three-state machine tracks progress:

- NO_CODE is the reset state, before any word has been received.
- ARMED means a word is pending.
- HOLD means the live set is current and nothing is pending.

The transitions are:

- A toggle event moves NO_CODE to ARMED.
- A PWM falling edge with no toggle event in the same cycle moves ARMED to HOLD.
- A toggle event in ARMED overwrites the pending word and stays in ARMED.
- A toggle event moves HOLD to ARMED.

Top module: `seg_code_rx`

## Requirements
- R1: After reset, every gate output is low and `pfm_mode` is 1, regardless of the PWM drives or PWM falling edges, until the first received word is applied.
- R2: A received word becomes live only at the first clock edge that sees `pwm_hs` low after it was high, and only once the word is pending. Until then, the previous enable set keeps driving the gates.
- R3: `hs_gate[i]` equals `pwm_hs` AND live high-side enable bit i. Bit 0 drives the 1-cell group, bit 1 the 2-cell group and bit 2 the 4-cell group.
- R4: In PWM mode (`pfm_mode` = 0), `ls_gate[i]` equals `pwm_ls` AND live low-side enable bit i, with the same bit weighting.
- R5: The word hs=3'b000, ls=3'b000 selects PFM. `pfm_mode` becomes 1, all `ls_gate` bits stay 0 even while `pwm_ls` is high, and the high-side enable set becomes PFM_HS_EN (default 3'b001).
- R6: In a word that is not all zero, a zero field is replaced by 3'b001 and the other field is kept as sent. The live enable sets are therefore never zero in PWM mode.
- R7: The code bus is sampled only when a change of `code_tgl`, passed through a two-flop synchronizer, is detected. A bus change without a toggle has no effect, even across PWM falling edges.
- R8: If a second word is received before a pending word has been applied, the second word replaces the first, and the first is never applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_tgl | input | 1 | Valid toggle from the control domain; each change announces a new word |
| hs_code | input | 3 | High-side segment code, held stable around each toggle |
| ls_code | input | 3 | Low-side segment code, held stable around each toggle |
| pwm_hs | input | 1 | High-side PWM drive, synchronous to clk |
| pwm_ls | input | 1 | Low-side PWM drive, synchronous to clk |
| hs_gate | output | 3 | High-side segment gate signals, one per binary-weighted group |
| ls_gate | output | 3 | Low-side segment gate signals, one per binary-weighted group |
| pfm_mode | output | 1 | 1 while pulse-frequency mode (rectifier off) is live |

## Verification
The hardest situation to reach from the ports is the boundary between the old and the new enable sets. This is the moment a pending word exists but the PWM has not yet fallen. The bench reaches it by holding both drives low while the toggle crosses the synchronizer, then raising only `pwm_hs` for one cycle. In that cycle the gates must still show the old set. The falling edge that ends the probe pulse is the edge that applies the new word, so the next low-side and high-side probes show the new set. Overwrite and ignored-bus cases reuse the same probe with two toggles, or with none, ahead of the edge.

// File: rtl/seg_rx_pkg.sv
package seg_rx_pkg;

    typedef enum logic [1:0] {
        ST_NO_CODE = 2'd0,
        ST_ARMED   = 2'd1,
        ST_HOLD    = 2'd2
    } rx_state_e;

endpackage

// File: rtl/seg_tgl_sync.sv
module seg_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_async,
    output logic new_evt
);
    // chain[0..STAGES-1] synchronize; chain[STAGES] remembers last seen level
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], tgl_async};
        end
    end

    assign new_evt = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/seg_code_norm.sv
module seg_code_norm #(
    parameter int             W         = 3,
    parameter logic [W-1:0]   PFM_HS_EN = 1
) (
    input  logic [W-1:0] hs_raw,
    input  logic [W-1:0] ls_raw,
    output logic [W-1:0] hs_norm,
    output logic [W-1:0] ls_norm,
    output logic         pfm_norm
);
    localparam logic [W-1:0] MIN_EN = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        pfm_norm = (hs_raw == '0) && (ls_raw == '0);
        if (pfm_norm) begin
            hs_norm = PFM_HS_EN;
            ls_norm = '0;
        end else begin
            hs_norm = (hs_raw == '0) ? MIN_EN : hs_raw;
            ls_norm = (ls_raw == '0) ? MIN_EN : ls_raw;
        end
    end

endmodule

// File: rtl/seg_apply_fsm.sv
module seg_apply_fsm
    import seg_rx_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         new_evt,
    input  logic [W-1:0] hs_norm,
    input  logic [W-1:0] ls_norm,
    input  logic         pfm_norm,
    input  logic         pwm_hs,
    output logic [W-1:0] hs_en,
    output logic [W-1:0] ls_en,
    output logic         pfm_live
);
    rx_state_e    state_q, state_d;
    logic         pwm_prev_q;
    logic         pwm_fall;
    logic [W-1:0] hs_pend_q, ls_pend_q;
    logic         pfm_pend_q;
    logic         apply;

    assign pwm_fall = pwm_prev_q && !pwm_hs;
    assign apply    = (state_q == ST_ARMED) && pwm_fall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NO_CODE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NO_CODE: if (new_evt) state_d = ST_ARMED;
            ST_ARMED:   if (pwm_fall && !new_evt) state_d = ST_HOLD;
            ST_HOLD:    if (new_evt) state_d = ST_ARMED;
            default:    state_d = ST_NO_CODE;
        endcase
    end

    // pending word, edge history and live enable set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_prev_q <= 1'b0;
            hs_pend_q  <= '0;
            ls_pend_q  <= '0;
            pfm_pend_q <= 1'b1;
            hs_en      <= '0;
            ls_en      <= '0;
            pfm_live   <= 1'b1;
        end else begin
            pwm_prev_q <= pwm_hs;
            if (apply) begin
                hs_en    <= hs_pend_q;
                ls_en    <= ls_pend_q;
                pfm_live <= pfm_pend_q;
            end
            if (new_evt) begin
                hs_pend_q  <= hs_norm;
                ls_pend_q  <= ls_norm;
                pfm_pend_q <= pfm_norm;
            end
        end
    end

endmodule

// File: rtl/seg_gate_stage.sv
module seg_gate_stage #(
    parameter int W = 3
) (
    input  logic         pwm_hs,
    input  logic         pwm_ls,
    input  logic         pfm_live,
    input  logic [W-1:0] hs_en,
    input  logic [W-1:0] ls_en,
    output logic [W-1:0] hs_gate,
    output logic [W-1:0] ls_gate
);
    for (genvar g = 0; g < W; g++) begin : g_seg
        assign hs_gate[g] = pwm_hs & hs_en[g];
        assign ls_gate[g] = pwm_ls & ls_en[g] & ~pfm_live;
    end

endmodule

// File: rtl/seg_code_rx.sv
module seg_code_rx #(
    parameter int                 SEG_W       = 3,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [SEG_W-1:0]   PFM_HS_EN   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             code_tgl,
    input  logic [SEG_W-1:0] hs_code,
    input  logic [SEG_W-1:0] ls_code,
    input  logic             pwm_hs,
    input  logic             pwm_ls,
    output logic [SEG_W-1:0] hs_gate,
    output logic [SEG_W-1:0] ls_gate,
    output logic             pfm_mode
);
    logic             new_evt;
    logic [SEG_W-1:0] hs_norm, ls_norm;
    logic             pfm_norm;
    logic [SEG_W-1:0] hs_en_q, ls_en_q;
    logic             pfm_q;

    seg_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tgl_async (code_tgl),
        .new_evt   (new_evt)
    );

    seg_code_norm #(.W(SEG_W), .PFM_HS_EN(PFM_HS_EN)) u_norm (
        .hs_raw   (hs_code),
        .ls_raw   (ls_code),
        .hs_norm  (hs_norm),
        .ls_norm  (ls_norm),
        .pfm_norm (pfm_norm)
    );

    seg_apply_fsm #(.W(SEG_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .new_evt  (new_evt),
        .hs_norm  (hs_norm),
        .ls_norm  (ls_norm),
        .pfm_norm (pfm_norm),
        .pwm_hs   (pwm_hs),
        .hs_en    (hs_en_q),
        .ls_en    (ls_en_q),
        .pfm_live (pfm_q)
    );

    seg_gate_stage #(.W(SEG_W)) u_gate (
        .pwm_hs   (pwm_hs),
        .pwm_ls   (pwm_ls),
        .pfm_live (pfm_q),
        .hs_en    (hs_en_q),
        .ls_en    (ls_en_q),
        .hs_gate  (hs_gate),
        .ls_gate  (ls_gate)
    );

    assign pfm_mode = pfm_q;

endmodule

// File: rtl/seg_code_rx_chk.sv
module seg_code_rx_chk #(
    parameter int W = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pwm_hs,
    input logic         pwm_ls,
    input logic [W-1:0] hs_gate,
    input logic [W-1:0] ls_gate,
    input logic         pfm_mode,
    input logic [W-1:0] hs_en,
    input logic [W-1:0] ls_en
);
    assert_hs_gate_needs_pwm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|hs_gate) |-> pwm_hs);

    assert_ls_gate_needs_pwm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ls_gate) |-> pwm_ls);

    assert_ls_off_in_pfm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pfm_mode |-> (ls_gate == '0 && ls_en == '0));

    assert_nonzero_in_pwm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pfm_mode |-> (hs_en != '0 && ls_en != '0));

    assert_update_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({hs_en, ls_en, pfm_mode}) |-> (!$past(pwm_hs) && $past(pwm_hs, 2)));

endmodule

bind seg_code_rx seg_code_rx_chk #(.W(SEG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_hs   (pwm_hs),
    .pwm_ls   (pwm_ls),
    .hs_gate  (hs_gate),
    .ls_gate  (ls_gate),
    .pfm_mode (pfm_mode),
    .hs_en    (hs_en_q),
    .ls_en    (ls_en_q)
);

// File: tb/seg_code_rx_tb.sv
module seg_code_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       code_tgl = 1'b0;
    logic [2:0] hs_code = '0;
    logic [2:0] ls_code = '0;
    logic       pwm_hs = 1'b0;
    logic       pwm_ls = 1'b0;
    logic [2:0] hs_gate, ls_gate;
    logic       pfm_mode;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    seg_code_rx u_dut (
        .clk(clk), .rst_n(rst_n), .code_tgl(code_tgl),
        .hs_code(hs_code), .ls_code(ls_code),
        .pwm_hs(pwm_hs), .pwm_ls(pwm_ls),
        .hs_gate(hs_gate), .ls_gate(ls_gate), .pfm_mode(pfm_mode)
    );

    // {hs_in, ls_in, exp_hs_en, exp_ls_en, exp_pfm}
    localparam int NV = 8;
    localparam logic [12:0] VEC [NV] = '{
        {3'd7, 3'd7, 3'd7, 3'd7, 1'b0},
        {3'd1, 3'd4, 3'd1, 3'd4, 1'b0},
        {3'd0, 3'd0, 3'd1, 3'd0, 1'b1},
        {3'd5, 3'd0, 3'd5, 3'd1, 1'b0},
        {3'd0, 3'd6, 3'd1, 3'd6, 1'b0},
        {3'd2, 3'd3, 3'd2, 3'd3, 1'b0},
        {3'd0, 3'd0, 3'd1, 3'd0, 1'b1},
        {3'd6, 3'd2, 3'd6, 3'd2, 1'b0}
    };

    logic [2:0] live_hs = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] h, input logic [2:0] l);
        hs_code  = h;
        ls_code  = l;
        code_tgl = ~code_tgl;
        repeat (4) @(negedge clk);
    endtask

    // probe old high side, create a falling edge, probe new low and high side
    task automatic probe(input string req, input logic [2:0] old_hs,
                         input logic [2:0] new_hs, input logic [2:0] new_ls,
                         input logic new_pfm);
        pwm_hs = 1'b1;
        @(negedge clk);
        check(hs_gate == old_hs, {req, " R2 old set before fall"}, hs_gate, old_hs);
        pwm_hs = 1'b0; pwm_ls = 1'b1;
        @(negedge clk);
        check(ls_gate == new_ls, {req, " R4 low side"}, ls_gate, new_ls);
        check(pfm_mode == new_pfm, {req, " R5 mode"}, pfm_mode, new_pfm);
        pwm_ls = 1'b0; pwm_hs = 1'b1;
        @(negedge clk);
        check(hs_gate == new_hs, {req, " R3 high side"}, hs_gate, new_hs);
        pwm_hs = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state with drives high and a falling edge, no code sent
        pwm_hs = 1'b1; pwm_ls = 1'b1;
        @(negedge clk);
        check(hs_gate == 0 && ls_gate == 0, "R1 gates off after reset", {hs_gate, ls_gate}, 0);
        check(pfm_mode == 1'b1, "R1 mode after reset", pfm_mode, 1);
        pwm_hs = 1'b0;
        @(negedge clk);
        check(hs_gate == 0 && ls_gate == 0, "R1 fall without code", {hs_gate, ls_gate}, 0);
        pwm_ls = 1'b0;
        @(negedge clk);

        // table walk: R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][12:10], VEC[i][9:7]);
            probe($sformatf("vec%0d", i), live_hs, VEC[i][6:4], VEC[i][3:1], VEC[i][0]);
            live_hs = VEC[i][6:4];
        end

        // R7: bus change without toggle is ignored
        hs_code = 3'd4; ls_code = 3'd5;
        repeat (4) @(negedge clk);
        probe("R7 no toggle", live_hs, live_hs, 3'd2, 1'b0);

        // R8: second word overwrites pending first
        send(3'd3, 3'd3);
        send(3'd4, 3'd7);
        probe("R8 latest wins", live_hs, 3'd4, 3'd7, 1'b0);
        live_hs = 3'd4;

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        pwm_hs = 1'b1; pwm_ls = 1'b1;
        @(negedge clk);
        check(hs_gate == 0 && ls_gate == 0 && pfm_mode, "R1 reset mid-run",
              {pfm_mode, hs_gate, ls_gate}, 64);
        pwm_hs = 1'b0; pwm_ls = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule